// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a virtual address into a physical address by reading up to three levels of translation tables held in memory. A client presents a 48-bit address word together with the base address of the first-level table. Only the low 34 bits of that word form the virtual address. The walker then reads one 64-bit descriptor per level through a simple read port and reports the outcome. The outcome is either a 48-bit physical address or a fault that names the level at which the walk stopped.

The first level maps 1 GB blocks, the second level maps 2 MB blocks and the third level maps 4 KB pages. Only one walk is in flight at a time. While a walk is running, the request side reports not-ready, and the memory side has at most one read outstanding.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `done`, `fault` and `mem_rd_valid` are 0.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both 1. On the next cycle `mem_rd_valid` pulses for exactly one cycle with `mem_rd_addr` = `root_base` + VA[33:30]*8.
- R3: Descriptor bit 0 is the valid flag and bit 1 is the table flag. A valid level-1 descriptor with the table flag clear completes the walk with `pa` = {desc[47:30], VA[29:0]}.
- R4: A valid level-1 table descriptor starts a level-2 read at {desc[47:12], 12'h000} + VA[29:21]*8. A valid level-2 descriptor with the table flag clear yields `pa` = {desc[47:21], VA[20:0]}.
- R5: A valid level-2 table descriptor starts a level-3 read at {desc[47:12], 12'h000} + VA[20:12]*8. A valid level-3 descriptor with the table flag clear yields `pa` = {desc[47:12], VA[11:0]}.
- R6: A descriptor whose bit 0 is clear ends the walk with `fault`=1 and `fault_level` equal to that level (1, 2 or 3), whatever bit 1 holds.
- R7: A valid level-3 descriptor with the table flag set ends the walk with `fault`=1 and `fault_level`=3.
- R8: `done` rises on the cycle after the deciding response and lasts exactly one cycle. `req_ready` returns to 1 on the following cycle.
- R9: Bits [47:34] of `req_addr`, and descriptor bits [63:48], do not affect read addresses or results.
- R10: While a walk is running, `req_ready` is 0. A response that arrives while no read is pending produces no `done` and no read.
- R11: A walk that completes without a fault reports `fault`=0 and `fault_level`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_addr | input | 48 | Address word; low 34 bits are the virtual address |
| root_base | input | 48 | Base of the first-level table |
| mem_rd_valid | output | 1 | One-cycle descriptor read strobe |
| mem_rd_addr | output | 48 | Byte address of the descriptor |
| mem_resp_valid | input | 1 | Descriptor data returned |
| mem_resp_data | input | 64 | Descriptor contents |
| done | output | 1 | Walk finished, one-cycle pulse |
| pa | output | 48 | Translated physical address (0 on fault) |
| fault | output | 1 | Walk ended in a translation fault |
| fault_level | output | 2 | Level that faulted, 0 when no fault |

## Verification
The bench builds the walker with its default parameters: 48-bit addresses, 64-bit descriptors, a 4 KB granule, 9-bit lower indices and a 4-bit top index. This gives block outcomes at levels 1 and 2, page outcomes at level 3, and fault endings at every level from one shared set of tables. The bench's memory model answers after one cycle in some walks and after four cycles in others, which exercises the wait on each read. Descriptors and request words carry set bits outside the decoded fields, so that a decoding slip changes a result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_ONE  = 2'd1;
  localparam lvl_t LVL_TWO  = 2'd2;
  localparam lvl_t LVL_THREE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_L1,
    ST_READ_L2,
    ST_READ_L3,
    ST_DONE
  } walk_st_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int GRAN_SHIFT  = 12,
  parameter int IDX_W       = 9,
  parameter int TOP_IDX_W   = 4,
  parameter int ENTRY_BYTES = 8,
  parameter int VA_W        = GRAN_SHIFT + 2 * IDX_W + TOP_IDX_W
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [VA_W-1:0]   va_i,
  input  lvl_t              lvl_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam int SH1 = GRAN_SHIFT + 2 * IDX_W;
  localparam int SH2 = GRAN_SHIFT + IDX_W;
  localparam int SH3 = GRAN_SHIFT;

  logic [ADDR_W-1:0] idx_ext;

  always_comb begin
    case (lvl_i)
      LVL_ONE: idx_ext = ADDR_W'(va_i[SH1 +: TOP_IDX_W]);
      LVL_TWO: idx_ext = ADDR_W'(va_i[SH2 +: IDX_W]);
      default: idx_ext = ADDR_W'(va_i[SH3 +: IDX_W]);
    endcase
  end

  assign addr_o = base_i + (idx_ext << ENTRY_SHIFT);
endmodule

// File: rtl/ptw_desc_dec.sv
module ptw_desc_dec
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int DESC_W     = 64,
  parameter int GRAN_SHIFT = 12,
  parameter int IDX_W      = 9,
  parameter int TOP_IDX_W  = 4,
  parameter int VA_W       = GRAN_SHIFT + 2 * IDX_W + TOP_IDX_W
) (
  input  logic [DESC_W-1:0] desc_i,
  input  logic [VA_W-1:0]   va_i,
  input  lvl_t              lvl_i,
  output logic              valid_o,
  output logic              table_o,
  output logic [ADDR_W-1:0] next_base_o,
  output logic [ADDR_W-1:0] leaf_pa_o
);
  localparam int LEVELS = 3;

  logic [ADDR_W-1:0] leaf [LEVELS];

  // One leaf address per level; the split point moves down by IDX_W each level.
  for (genvar g = 0; g < LEVELS; g++) begin : g_leaf
    localparam int SH = GRAN_SHIFT + (LEVELS - 1 - g) * IDX_W;
    assign leaf[g] = {desc_i[ADDR_W-1:SH], va_i[SH-1:0]};
  end

  always_comb begin
    case (lvl_i)
      LVL_ONE: leaf_pa_o = leaf[0];
      LVL_TWO: leaf_pa_o = leaf[1];
      default: leaf_pa_o = leaf[2];
    endcase
  end

  assign valid_o     = desc_i[0];
  assign table_o     = desc_i[1];
  assign next_base_o = {desc_i[ADDR_W-1:GRAN_SHIFT], {GRAN_SHIFT{1'b0}}};

  logic unused_desc_bits;
  assign unused_desc_bits = ^{desc_i[DESC_W-1:ADDR_W], desc_i[GRAN_SHIFT-1:2]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int DESC_W      = 64,
  parameter int GRAN_SHIFT  = 12,
  parameter int IDX_W       = 9,
  parameter int TOP_IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] root_base,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_resp_valid,
  input  logic [DESC_W-1:0] mem_resp_data,
  output logic              done,
  output logic [ADDR_W-1:0] pa,
  output logic              fault,
  output logic [1:0]        fault_level
);
  localparam int VA_W = GRAN_SHIFT + 2 * IDX_W + TOP_IDX_W;

  walk_st_t          st_q;
  logic [VA_W-1:0]   va_q;
  lvl_t              lvl_cur;
  logic              d_valid, d_table;
  logic [ADDR_W-1:0] d_next_base, d_leaf;
  logic [ADDR_W-1:0] gen_base, gen_addr;
  logic [VA_W-1:0]   gen_va;
  lvl_t              gen_lvl;

  always_comb begin
    case (st_q)
      ST_READ_L1: lvl_cur = LVL_ONE;
      ST_READ_L2: lvl_cur = LVL_TWO;
      ST_READ_L3: lvl_cur = LVL_THREE;
      default:    lvl_cur = LVL_NONE;
    endcase
  end

  // Idle: first-level address from the request; walking: next level from the descriptor.
  always_comb begin
    if (st_q == ST_IDLE) begin
      gen_base = root_base;
      gen_va   = req_addr[VA_W-1:0];
      gen_lvl  = LVL_ONE;
    end else begin
      gen_base = d_next_base;
      gen_va   = va_q;
      gen_lvl  = lvl_t'(lvl_cur + 2'd1);
    end
  end

  ptw_addr_gen #(
    .ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT), .IDX_W(IDX_W),
    .TOP_IDX_W(TOP_IDX_W), .ENTRY_BYTES(DESC_W / 8), .VA_W(VA_W)
  ) u_addr (
    .base_i(gen_base), .va_i(gen_va), .lvl_i(gen_lvl), .addr_o(gen_addr)
  );

  ptw_desc_dec #(
    .ADDR_W(ADDR_W), .DESC_W(DESC_W), .GRAN_SHIFT(GRAN_SHIFT),
    .IDX_W(IDX_W), .TOP_IDX_W(TOP_IDX_W), .VA_W(VA_W)
  ) u_dec (
    .desc_i(mem_resp_data), .va_i(va_q), .lvl_i(lvl_cur),
    .valid_o(d_valid), .table_o(d_table),
    .next_base_o(d_next_base), .leaf_pa_o(d_leaf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      va_q         <= '0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      done         <= 1'b0;
      pa           <= '0;
      fault        <= 1'b0;
      fault_level  <= LVL_NONE;
    end else begin
      mem_rd_valid <= 1'b0;
      done         <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q         <= req_addr[VA_W-1:0];
            mem_rd_addr  <= gen_addr;
            mem_rd_valid <= 1'b1;
            st_q         <= ST_READ_L1;
          end
        end
        ST_READ_L1, ST_READ_L2, ST_READ_L3: begin
          if (mem_resp_valid) begin
            if (d_valid && d_table && lvl_cur != LVL_THREE) begin
              mem_rd_addr  <= gen_addr;
              mem_rd_valid <= 1'b1;
              st_q         <= (st_q == ST_READ_L1) ? ST_READ_L2 : ST_READ_L3;
            end else begin
              st_q <= ST_DONE;
              done <= 1'b1;
              if (d_valid && !d_table) begin
                pa          <= d_leaf;
                fault       <= 1'b0;
                fault_level <= LVL_NONE;
              end else begin
                pa          <= '0;
                fault       <= 1'b1;
                fault_level <= lvl_cur;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);

  logic unused_hi;
  assign unused_hi = ^req_addr[ADDR_W-1:VA_W];
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       mem_rd_valid,
  input logic       done,
  input logic       fault,
  input logic [1:0] fault_level
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  ready_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> req_ready);

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |=> !mem_rd_valid);

  // R2
  accept_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> mem_rd_valid);

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready);

  // R6
  fault_has_level_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (fault_level != 2'd0));

  // R11
  ok_no_level_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (fault_level == 2'd0));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_valid(mem_rd_valid), .done(done), .fault(fault),
  .fault_level(fault_level)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_addr = '0;
  logic [47:0] root_base = '0;
  logic        mem_rd_valid;
  logic [47:0] mem_rd_addr;
  logic        mem_resp_valid = 1'b0;
  logic [63:0] mem_resp_data = '0;
  logic        done;
  logic [47:0] pa;
  logic        fault;
  logic [1:0]  fault_level;

  always #2.5 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .root_base(root_base),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .done(done), .pa(pa), .fault(fault), .fault_level(fault_level)
  );

  int total = 0;
  int bad = 0;
  int lat = 1;
  bit inject = 0;

  logic [63:0] mem [logic [47:0]];
  logic [47:0] addr_q [$];
  bit          ef_q [$];
  logic [1:0]  el_q [$];
  logic [47:0] ep_q [$];
  string       et_q [$];

  localparam logic [47:0] ROOT = 48'h0000_4000_0000;
  localparam logic [47:0] TB2  = 48'h0000_0012_3000;
  localparam logic [47:0] TB3  = 48'h0000_0045_6000;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [33:0] mkva(input logic [3:0] i1, input logic [8:0] i2,
                                       input logic [8:0] i3, input logic [11:0] off);
    return {i1, i2, i3, off};
  endfunction

  // Memory model: one read at a time, answers after lat cycles.
  initial begin
    int pend = 0;
    logic [47:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_resp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_resp_valid = 1'b1;
          mem_resp_data = mem.exists(paddr) ? mem[paddr] : 64'h0;
        end
      end
      if (inject) begin
        mem_resp_valid = 1'b1;
        mem_resp_data = 64'h3;
        inject = 0;
      end
      if (mem_rd_valid) begin
        if (addr_q.size() == 0)
          check(0, "R2", "unexpected read addr", mem_rd_addr, 0);
        else begin
          logic [47:0] ea;
          ea = addr_q.pop_front();
          check(mem_rd_addr == ea, "R2/R4/R5", "descriptor read address", mem_rd_addr, ea);
        end
        pend = lat;
        paddr = mem_rd_addr;
      end
    end
  end

  // Monitor: scoreboard compare on each done.
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (ef_q.size() == 0) check(0, "R8", "done with no walk", 1, 0);
        else begin
          bit ef; logic [1:0] el; logic [47:0] ep; string et;
          ef = ef_q.pop_front(); el = el_q.pop_front();
          ep = ep_q.pop_front(); et = et_q.pop_front();
          check(fault == ef, et, "fault", fault, ef);
          check(fault_level == el, et, "fault_level", fault_level, el);
          if (!ef) check(pa == ep, et, "pa", pa, ep);
          @(negedge clk);
          check(done == 1'b0, "R8", "done width", done, 0);
          check(req_ready == 1'b1, "R8", "ready after done", req_ready, 1);
        end
      end
    end
  end

  task automatic walk(input logic [47:0] a, input bit f, input logic [1:0] l,
                      input logic [47:0] epa, input int n, input logic [47:0] a0,
                      input logic [47:0] a1, input logic [47:0] a2, input string tag);
    addr_q.push_back(a0);
    if (n > 1) addr_q.push_back(a1);
    if (n > 2) addr_q.push_back(a2);
    ef_q.push_back(f); el_q.push_back(l); ep_q.push_back(epa); et_q.push_back(tag);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; root_base = ROOT;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10", "ready during walk", req_ready, 0);
    while (ef_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [33:0] va;
    // Table contents; bits [63:48] set in places to show they are ignored (R9).
    mem[ROOT + 48'd16] = {16'hFFFF, 18'h2D0F1, 28'h0, 2'b01};
    mem[ROOT + 48'd24] = {16'h0, TB2[47:12], 10'h0, 2'b11};
    mem[ROOT + 48'd8]  = 64'h2;
    mem[TB2 + 48'd40]  = {16'h0, 27'h5A5A5A5, 19'h0, 2'b01};
    mem[TB2 + 48'd48]  = {16'h0, TB3[47:12], 10'h0, 2'b11};
    mem[TB3 + 48'd56]  = {16'hABCD, 36'h9_8765_4321, 10'h0, 2'b01};
    mem[TB3 + 48'd72]  = {16'h0, TB3[47:12], 10'h0, 2'b11};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    check(done == 1'b0, "R1", "reset done", done, 0);
    check(fault == 1'b0, "R1", "reset fault", fault, 0);
    check(mem_rd_valid == 1'b0, "R1", "reset rd", mem_rd_valid, 0);

    // R10: stray response while idle
    inject = 1;
    repeat (3) begin
      @(negedge clk);
      check(done == 1'b0 && mem_rd_valid == 1'b0, "R10", "stray response", {done, mem_rd_valid}, 0);
    end
    check(req_ready == 1'b1, "R10", "idle after stray", req_ready, 1);

    // R3, R9: 1 GB block, upper request bits set
    va = mkva(4'd2, 9'h1A3, 9'h0F5, 12'hABC);
    walk({14'h2ABC, va}, 0, 2'd0, {18'h2D0F1, va[29:0]}, 1, ROOT + 48'd16, 0, 0, "R3/R9/R11");

    // R4: 2 MB block
    va = mkva(4'd3, 9'd5, 9'h111, 12'h123);
    walk({14'h0, va}, 0, 2'd0, {27'h5A5A5A5, va[20:0]}, 2, ROOT + 48'd24, TB2 + 48'd40, 0, "R4");

    // R5: 4 KB page
    va = mkva(4'd3, 9'd6, 9'd7, 12'hFED);
    walk({14'h3FFF, va}, 0, 2'd0, {36'h9_8765_4321, va[11:0]}, 3,
         ROOT + 48'd24, TB2 + 48'd48, TB3 + 48'd56, "R5/R9");

    // R6: invalid at each level (level 1 entry has bit 1 set)
    va = mkva(4'd1, 9'd0, 9'd0, 12'h0);
    walk({14'h0, va}, 1, 2'd1, 0, 1, ROOT + 48'd8, 0, 0, "R6 level1");
    va = mkva(4'd0, 9'd0, 9'd0, 12'h0);
    walk({14'h0, va}, 1, 2'd1, 0, 1, ROOT, 0, 0, "R6 level1 empty");
    va = mkva(4'd3, 9'd7, 9'd0, 12'h0);
    walk({14'h0, va}, 1, 2'd2, 0, 2, ROOT + 48'd24, TB2 + 48'd56, 0, "R6 level2");
    va = mkva(4'd3, 9'd6, 9'd8, 12'h0);
    walk({14'h0, va}, 1, 2'd3, 0, 3, ROOT + 48'd24, TB2 + 48'd48, TB3 + 48'd64, "R6 level3");

    // R7: table descriptor at level 3
    va = mkva(4'd3, 9'd6, 9'd9, 12'h0);
    walk({14'h0, va}, 1, 2'd3, 0, 3, ROOT + 48'd24, TB2 + 48'd48, TB3 + 48'd72, "R7");

    // Slower memory
    lat = 4;
    va = mkva(4'd3, 9'd6, 9'd7, 12'h001);
    walk({14'h1234, va}, 0, 2'd0, {36'h9_8765_4321, va[11:0]}, 3,
         ROOT + 48'd24, TB2 + 48'd48, TB3 + 48'd56, "R5 slow");
    va = mkva(4'd3, 9'd5, 9'h1FF, 12'hFFF);
    walk({14'h0, va}, 0, 2'd0, {27'h5A5A5A5, va[20:0]}, 2, ROOT + 48'd24, TB2 + 48'd40, 0, "R4 slow");

    check(addr_q.size() == 0, "R2", "reads left over", addr_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule